// File: doc/BRIEF.md
# Pin-Sequence Link Activation Detector

Two shared pins normally carry quadrature output from this chip's own drivers. An external master can take the pins over by forcing a timed series of four level combinations onto them. This block watches the pins and times each combination with a free-running reference clock. It accepts the series only if every step is in order and has a valid length.

The first step is both pins high, and its measured length becomes the reference interval. Each of the three later steps must last as long as the reference, within a ±10% window. When the last step ends within its window, the block drops its driver enable and raises a link-active flag. It also emits a one-cycle activation pulse and routes the synchronised pins out as link clock and link data. Any error in order or length sends the block back to idle, and the quadrature drivers stay enabled.

The flag stays set until a synchronous reset or an explicit deactivate request.

Top module: `link_wake_detector`

## Requirements
- R1: After reset `drv_en_o` is 1, and `link_active_o`, `act_pulse_o`, `link_clk_o` and `link_dat_o` are 0.
- R2: The first step is pins {a,b}=2'b11. It is accepted only if it lasts between T1_MIN_CYC and T1_MAX_CYC reference cycles inclusive, which is 25 to 200 in the bench setup. Its length is T1.
- R3: The second step is {a,b}=2'b01. It is accepted if its length lies in [T1 - floor(T1/10), T1 + floor(T1/10)].
- R4: The third step is {a,b}=2'b00, with the same window as R3.
- R5: The fourth step is {a,b}=2'b10, with the same window. Activation occurs when the pins leave 2'b10 with a length inside the window.
- R6: Any combination other than the next expected one ends the attempt. The block returns to idle with the drivers enabled.
- R7: A step that is too short when it ends, or that is still present once it has reached its upper limit, ends the attempt with the drivers enabled.
- R8: On activation `drv_en_o` goes to 0 and `link_active_o` goes to 1. `act_pulse_o` is high for exactly one cycle.
- R9: `link_active_o` stays at 1 until `deact_i` or `srst_i` is sampled high. The next cycle, the block is idle with the drivers enabled.
- R10: While the link is active, `link_clk_o` follows synchronised pin a and `link_dat_o` follows synchronised pin b. Otherwise both are 0.
- R11: An attempt starts only when the pins change into 2'b11. Pins that are still 2'b11 after an abort do not start a new attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset to idle |
| deact_i | input | 1 | Leave link mode, return to idle |
| pin_a_i | input | 1 | Sampled level of the first shared pin |
| pin_b_i | input | 1 | Sampled level of the second shared pin |
| drv_en_o | output | 1 | Enable for the quadrature drivers on both pins |
| link_active_o | output | 1 | Serial link mode is active |
| act_pulse_o | output | 1 | One-cycle pulse at activation |
| link_clk_o | output | 1 | Link clock taken from pin a in link mode |
| link_dat_o | output | 1 | Link data taken from pin b in link mode |

## Verification
The checker watches several rules on every cycle:
- The activation pulse lasts one cycle and coincides with the rise of the link flag.
- The flag holds until deactivate or synchronous reset, and one of them always clears it.
- The link outputs are quiet outside link mode.

Whether a step's length lands inside or outside its window can only be shown by the bench's timed patterns. Those patterns cover lengths at, just inside and just outside each limit, along with out-of-order steps and re-entry after an abort.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STEP1, ST_STEP2, ST_STEP3, ST_STEP4, ST_LINK
  } lwd_state_e;

  localparam logic [1:0] COMBO_S1 = 2'b11;
  localparam logic [1:0] COMBO_S2 = 2'b01;
  localparam logic [1:0] COMBO_S3 = 2'b00;
  localparam logic [1:0] COMBO_S4 = 2'b10;
endpackage

// File: rtl/lwd_sync.sv
module lwd_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/lwd_counter.sv
module lwd_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (load_i)                    cnt_o <= CNT_W'(1);
    else if (inc_i && cnt_o != CNT_SAT) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/lwd_window.sv
module lwd_window #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] ref_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);
  logic [CNT_W-1:0] tenth;
  assign tenth = ref_i / CNT_W'(10);

  // floor(T1/10) narrows both edges of the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (capture_i) begin
      lo_o <= ref_i - tenth;
      hi_o <= ref_i + tenth;
    end
  end
endmodule

// File: rtl/link_wake_detector.sv
module link_wake_detector
  import lwd_pkg::*;
#(
  parameter int REF_KHZ   = 50000,
  parameter int T1_MIN_US = 250,
  parameter int T1_MAX_US = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic deact_i,
  input  logic pin_a_i,
  input  logic pin_b_i,
  output logic drv_en_o,
  output logic link_active_o,
  output logic act_pulse_o,
  output logic link_clk_o,
  output logic link_dat_o
);
  localparam int T1_MIN_CYC = REF_KHZ * T1_MIN_US / 1000;
  localparam int T1_MAX_CYC = REF_KHZ * T1_MAX_US / 1000;
  localparam int CNT_W      = $clog2(T1_MAX_CYC + T1_MAX_CYC / 10 + 2);

  logic [1:0] combo, prev_combo_q;
  lwd_state_e state_q, state_d;
  logic load, inc, capture, activate;
  logic [CNT_W-1:0] cnt, win_lo, win_hi, lim_lo, lim_hi;
  logic [1:0] exp_combo, nxt_combo;
  logic in_win, link_q, pulse_q;

  lwd_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pin_a_i, pin_b_i}),
    .q_o   (combo)
  );

  lwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .inc_i (inc),
    .cnt_o (cnt)
  );

  lwd_window #(.CNT_W(CNT_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .ref_i    (cnt),
    .lo_o     (win_lo),
    .hi_o     (win_hi)
  );

  always_comb begin
    exp_combo = COMBO_S1;
    nxt_combo = COMBO_S2;
    unique case (state_q)
      ST_STEP2: begin exp_combo = COMBO_S2; nxt_combo = COMBO_S3; end
      ST_STEP3: begin exp_combo = COMBO_S3; nxt_combo = COMBO_S4; end
      ST_STEP4: begin exp_combo = COMBO_S4; nxt_combo = COMBO_S1; end
      default:  ;
    endcase
  end

  assign lim_lo = (state_q == ST_STEP1) ? CNT_W'(T1_MIN_CYC) : win_lo;
  assign lim_hi = (state_q == ST_STEP1) ? CNT_W'(T1_MAX_CYC) : win_hi;
  assign in_win = (cnt >= lim_lo) && (cnt <= lim_hi);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    inc      = 1'b0;
    capture  = 1'b0;
    activate = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (combo == COMBO_S1 && prev_combo_q != COMBO_S1) begin
          state_d = ST_STEP1;
          load    = 1'b1;
        end
      end
      ST_STEP1, ST_STEP2, ST_STEP3, ST_STEP4: begin
        if (combo == exp_combo) begin
          if (cnt >= lim_hi) state_d = ST_IDLE;
          else               inc     = 1'b1;
        end else if (!in_win) begin
          state_d = ST_IDLE;
        end else if (state_q == ST_STEP4) begin
          state_d  = ST_LINK;
          activate = 1'b1;
        end else if (combo == nxt_combo) begin
          load    = 1'b1;
          capture = (state_q == ST_STEP1);
          state_d = (state_q == ST_STEP1) ? ST_STEP2 :
                    (state_q == ST_STEP2) ? ST_STEP3 : ST_STEP4;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_LINK: ;
      default: state_d = ST_IDLE;
    endcase
    if (srst_i || deact_i) begin
      state_d  = ST_IDLE;
      load     = 1'b0;
      capture  = 1'b0;
      activate = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      prev_combo_q <= 2'b00;
      link_q       <= 1'b0;
      pulse_q      <= 1'b0;
    end else begin
      state_q      <= state_d;
      prev_combo_q <= srst_i ? 2'b00 : combo;
      pulse_q      <= activate;
      if (srst_i || deact_i) link_q <= 1'b0;
      else if (activate)     link_q <= 1'b1;
    end
  end

  assign link_active_o = link_q;
  assign act_pulse_o   = pulse_q;
  assign drv_en_o      = !link_q;
  assign link_clk_o    = link_q & combo[1];
  assign link_dat_o    = link_q & combo[0];
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic deact_i,
  input logic drv_en_o,
  input logic link_active_o,
  input logic act_pulse_o,
  input logic link_clk_o,
  input logic link_dat_o
);
  // R8
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_pulse_o |=> !act_pulse_o);

  // R8
  pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_active_o) |-> act_pulse_o);

  // R9
  link_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_active_o && !deact_i && !srst_i) |=> link_active_o);

  // R9
  link_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deact_i || srst_i) |=> (!link_active_o && drv_en_o));

  // R10
  link_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_active_o |-> (!link_clk_o && !link_dat_o));
endmodule

bind link_wake_detector lwd_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srst_i       (srst_i),
  .deact_i      (deact_i),
  .drv_en_o     (drv_en_o),
  .link_active_o(link_active_o),
  .act_pulse_o  (act_pulse_o),
  .link_clk_o   (link_clk_o),
  .link_dat_o   (link_dat_o)
);

// File: tb/link_wake_detector_test.sv
module link_wake_detector_test;
  logic clk = 1'b0, rst_ni = 1'b0, srst_i = 1'b0, deact_i = 1'b0;
  logic pin_a_i = 1'b0, pin_b_i = 1'b0;
  logic drv_en_o, link_active_o, act_pulse_o, link_clk_o, link_dat_o;
  int n_run = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // 100 kHz reference: step-1 limits are 25..200 cycles
  link_wake_detector #(.REF_KHZ(100), .T1_MIN_US(250), .T1_MAX_US(2000)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst_i), .deact_i(deact_i),
    .pin_a_i(pin_a_i), .pin_b_i(pin_b_i), .drv_en_o(drv_en_o),
    .link_active_o(link_active_o), .act_pulse_o(act_pulse_o),
    .link_clk_o(link_clk_o), .link_dat_o(link_dat_o)
  );

  always @(negedge clk) if (act_pulse_o) pulses++;

  // {len1, len2, len3, len4, expected link}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {8'd100, 8'd100, 8'd100, 8'd100, 1'b1},
    {8'd100, 8'd90,  8'd110, 8'd100, 1'b1},
    {8'd100, 8'd89,  8'd100, 8'd100, 1'b0},
    {8'd100, 8'd100, 8'd111, 8'd100, 1'b0},
    {8'd25,  8'd25,  8'd25,  8'd25,  1'b1},
    {8'd24,  8'd24,  8'd24,  8'd24,  1'b0},
    {8'd200, 8'd180, 8'd220, 8'd200, 1'b1},
    {8'd201, 8'd201, 8'd201, 8'd201, 1'b0},
    {8'd50,  8'd45,  8'd55,  8'd50,  1'b1},
    {8'd50,  8'd50,  8'd50,  8'd44,  1'b0},
    {8'd100, 8'd100, 8'd100, 8'd111, 1'b0},
    {8'd100, 8'd100, 8'd100, 8'd110, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(logic a, logic b, int n);
    pin_a_i = a;
    pin_b_i = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_seq(int l1, int l2, int l3, int l4);
    hold(1'b1, 1'b1, l1);
    hold(1'b0, 1'b1, l2);
    hold(1'b0, 1'b0, l3);
    hold(1'b1, 1'b0, l4);
    hold(1'b0, 1'b0, 6);
  endtask

  task automatic deactivate();
    deact_i = 1'b1;
    @(negedge clk);
    deact_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 drv_en", drv_en_o, 1);
    check("R1 link", link_active_o, 0);
    check("R1 pulse", act_pulse_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R7 R8: timed patterns, step lengths at and beyond limits
    for (int i = 0; i < NV; i++) begin
      pulses = 0;
      run_seq(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
      check($sformatf("R2-5/R7 vec%0d link", i), link_active_o, VEC[i][0]);
      check($sformatf("R8 vec%0d drv_en", i), drv_en_o, !VEC[i][0]);
      check($sformatf("R8 vec%0d pulses", i), pulses, VEC[i][0]);
      deactivate();
    end

    // R10: pin routing only in link mode
    hold(1'b1, 1'b0, 4);
    check("R10 idle clk", link_clk_o, 0);
    hold(1'b0, 1'b0, 4);
    run_seq(60, 60, 60, 60);
    hold(1'b1, 1'b0, 4);
    check("R10 link clk", link_clk_o, 1);
    check("R10 link dat", link_dat_o, 0);
    hold(1'b0, 1'b1, 4);
    check("R10 link clk low", link_clk_o, 0);
    check("R10 link dat high", link_dat_o, 1);

    // R9: held until sync reset; sync reset returns idle
    hold(1'b0, 1'b0, 20);
    check("R9 held", link_active_o, 1);
    srst_i = 1'b1;
    @(negedge clk);
    srst_i = 1'b0;
    @(negedge clk);
    check("R9 srst link", link_active_o, 0);
    check("R9 srst drv_en", drv_en_o, 1);

    // R9: deactivate clears
    run_seq(60, 60, 60, 60);
    check("R9 active again", link_active_o, 1);
    deactivate();
    check("R9 deact link", link_active_o, 0);

    // R6: out-of-order step (11 then 00)
    hold(1'b1, 1'b1, 60);
    hold(1'b0, 1'b0, 60);
    hold(1'b1, 1'b0, 60);
    hold(1'b0, 1'b0, 6);
    check("R6 order", link_active_o, 0);

    // R6: step 2 followed by step 4 combination
    hold(1'b1, 1'b1, 60);
    hold(1'b0, 1'b1, 60);
    hold(1'b1, 1'b0, 60);
    hold(1'b0, 1'b0, 6);
    check("R6 skip", link_active_o, 0);

    // R11: overlong step 1 aborts; pins still 11 must not restart
    hold(1'b1, 1'b1, 201 + 60);
    hold(1'b0, 1'b1, 60);
    hold(1'b0, 1'b0, 60);
    hold(1'b1, 1'b0, 60);
    hold(1'b0, 1'b0, 6);
    check("R11 no restart", link_active_o, 0);
    check("R11 drv_en", drv_en_o, 1);

    // R11: fresh entry into 11 after abort works
    run_seq(60, 60, 60, 60);
    check("R11 fresh entry", link_active_o, 1);
    deactivate();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule